// File: doc/BRIEF.md
# Asynchronous Static RAM Access Controller

This block sits between a clocked host and an external asynchronous static RAM of 131,072 bytes. The host issues a single read or write request with a valid flag, a direction bit, a 17-bit address and a byte of write data. The controller turns that request into a timed sequence on the memory's active-low chip-select, output-enable and write-strobe pins, its address lines and a split bidirectional byte bus (output value, output enable, input sample).

Each interval of the sequence is a whole number of clock cycles. The counts come from nanosecond parameters and the clock period, rounded up. A write runs through a setup cycle, a strobe pulse long enough for both data setup and pulse width, and a hold cycle. In that hold cycle the strobe is already released but the data is still driven. A read holds chip select and output enable low until the data is safe to sample, registers it, and returns it with a one-cycle valid pulse. A turnaround gap follows every read, so the memory can release the bus before the controller drives it again. When idle, the memory is left deselected in standby and the controller's bus drivers are off.

Top module: `sram_async_ctrl`

## Requirements
- R1: Out of reset and in every idle cycle, `mem_ce_n`, `mem_oe_n` and `mem_we_n` are all 1, `mem_dq_oe` is 0 and `req_ready` is 1.
- R2: With a 10 ns clock and default limits, an accepted write holds `mem_ce_n` low for exactly 3 cycles. `mem_we_n` is low only within that window, for exactly 1 cycle, in the middle cycle. `wr_done` is 1 for one cycle, in the first cycle in which `req_ready` is 1 again.
- R3: During a write, `mem_dq_oe` is 1 and `mem_dq_o` holds the request's byte for every cycle in which `mem_we_n` is low, and for the cycle after `mem_we_n` rises.
- R4: With the default setting (`OE_LOW_WR` = 0), `mem_oe_n` is 1 whenever `mem_we_n` is 0.
- R5: An accepted read holds `mem_ce_n` and `mem_oe_n` low for exactly 2 cycles. The byte on `mem_dq_i` at the end of the last of these cycles appears on `rsp_rdata`, with `rsp_valid` 1 for exactly one cycle, in the cycle after the pins rise. `req_ready` returns one turnaround cycle later, so a read occupies the controller for 3 cycles.
- R6: `mem_dq_oe` is 1 only when `mem_oe_n` was 1 in the previous cycle, so the controller never drives the bus while the memory may still drive it.
- R7: A request presented while `req_ready` is 0 is ignored: it changes no memory location and produces no response.
- R8: `mem_addr` does not change while `mem_ce_n` stays low.
- R9: A byte written to any address, including 0x00000 and 0x1FFFF, reads back unchanged, and later writes overwrite earlier ones.
- R10: `req_ready` is 1 exactly when the controller is idle, and a request is accepted only at a clock edge where both `req_valid` and `req_ready` are 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Host request present |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 17 | Host byte address |
| req_wdata | input | 8 | Host write byte |
| req_ready | output | 1 | Controller idle, request will be taken |
| rsp_valid | output | 1 | One-cycle pulse: read byte available |
| rsp_rdata | output | 8 | Registered read byte |
| wr_done | output | 1 | One-cycle pulse: write finished |
| mem_ce_n | output | 1 | Memory chip select, active low |
| mem_oe_n | output | 1 | Memory output enable, active low |
| mem_we_n | output | 1 | Memory write strobe, active low |
| mem_addr | output | 17 | Memory address |
| mem_dq_o | output | 8 | Byte driven onto the data bus |
| mem_dq_oe | output | 1 | Enable of the controller's bus drivers |
| mem_dq_i | input | 8 | Byte sampled from the data bus |

## Verification
The checker watches the pin rules that must hold on every cycle. These are the standby state while idle, the write strobe nested inside chip select, output enable high during writes, and the turnaround before the drivers switch on. It also covers the address held under chip select, the data held across the strobe's rising edge, and the single-cycle response pulse. The exact cycle counts of each sequence, the ignoring of requests while busy and the integrity of stored data can only be shown by the bench. It uses a behavioural memory that stores bytes on the strobe's rising edge, returns data only after enough access time, and flags contention or data changing during a strobe.

// File: rtl/sramc_pkg.sv
package sramc_pkg;

  typedef enum logic [2:0] {
    S_IDLE = 3'd0,
    S_WSU  = 3'd1,
    S_WP   = 3'd2,
    S_WH   = 3'd3,
    S_RD   = 3'd4,
    S_TURN = 3'd5
  } seq_st_t;

  // Round a nanosecond limit up to whole clock cycles, never below one.
  function automatic int ns_to_cyc(input int ns, input int clk_ns);
    int c;
    c = (ns + clk_ns - 1) / clk_ns;
    if (c < 1) c = 1;
    return c;
  endfunction

  function automatic int max_i(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/sramc_timer.sv
// Down counter used for every timed interval of the pin sequence.
module sramc_timer #(
  parameter int CW = 2
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          load,
  input  logic [CW-1:0] load_val,
  output logic          zero
);

  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt <= '0;
    end else if (load) begin
      cnt <= load_val;
    end else if (cnt != '0) begin
      cnt <= cnt - 1'b1;
    end
  end

  assign zero = (cnt == '0);

endmodule

// File: rtl/sramc_seq.sv
// Cycle sequencer: owns the control pins and the driver enable as registers.
module sramc_seq
  import sramc_pkg::*;
#(
  parameter int CW        = 2,
  parameter int RD_CNT    = 2,
  parameter int WP_CNT    = 1,
  parameter int TURN_CNT  = 1,
  parameter bit OE_LOW_WR = 1'b0
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          req_valid,
  input  logic          req_write,
  input  logic          t_zero,
  output logic          t_load,
  output logic [CW-1:0] t_val,
  output logic          idle,
  output logic          accept,
  output logic          cap_now,
  output logic          ce_n,
  output logic          oe_n,
  output logic          we_n,
  output logic          drv,
  output logic          wr_done
);

  localparam logic [CW-1:0] RD_LD   = CW'(RD_CNT - 1);
  localparam logic [CW-1:0] WP_LD   = CW'(WP_CNT - 1);
  localparam logic [CW-1:0] TURN_LD = CW'(TURN_CNT - 1);
  // In the write setup cycle the controller drives only when output enable stays high.
  localparam logic DRV_IN_SETUP = !OE_LOW_WR;
  localparam logic OE_N_IN_WR   = !OE_LOW_WR;

  seq_st_t st;

  assign idle    = (st == S_IDLE);
  assign accept  = idle && req_valid;
  assign cap_now = (st == S_RD) && t_zero;

  always_comb begin
    t_load = 1'b0;
    t_val  = '0;
    unique case (st)
      S_IDLE: if (req_valid && !req_write) begin
        t_load = 1'b1;
        t_val  = RD_LD;
      end
      S_WSU: begin
        t_load = 1'b1;
        t_val  = WP_LD;
      end
      S_RD: if (t_zero) begin
        t_load = 1'b1;
        t_val  = TURN_LD;
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st      <= S_IDLE;
      ce_n    <= 1'b1;
      oe_n    <= 1'b1;
      we_n    <= 1'b1;
      drv     <= 1'b0;
      wr_done <= 1'b0;
    end else begin
      wr_done <= 1'b0;
      unique case (st)
        S_IDLE: if (req_valid) begin
          ce_n <= 1'b0;
          if (req_write) begin
            st   <= S_WSU;
            oe_n <= OE_N_IN_WR;
            drv  <= DRV_IN_SETUP;
          end else begin
            st   <= S_RD;
            oe_n <= 1'b0;
          end
        end
        S_WSU: begin
          we_n <= 1'b0;
          st   <= S_WP;
        end
        S_WP: begin
          drv <= 1'b1;
          if (t_zero) begin
            we_n <= 1'b1;
            st   <= S_WH;
          end
        end
        S_WH: begin
          ce_n    <= 1'b1;
          oe_n    <= 1'b1;
          drv     <= 1'b0;
          wr_done <= 1'b1;
          st      <= S_IDLE;
        end
        S_RD: if (t_zero) begin
          ce_n <= 1'b1;
          oe_n <= 1'b1;
          st   <= S_TURN;
        end
        S_TURN: if (t_zero) begin
          st <= S_IDLE;
        end
        default: st <= S_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/sramc_dp.sv
// Address, write-data and read-capture registers.
module sramc_dp #(
  parameter int AW = 17,
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          accept,
  input  logic [AW-1:0] req_addr,
  input  logic [DW-1:0] req_wdata,
  input  logic          cap_now,
  input  logic [DW-1:0] mem_dq_i,
  output logic [AW-1:0] mem_addr,
  output logic [DW-1:0] mem_dq_o,
  output logic          rsp_valid,
  output logic [DW-1:0] rsp_rdata
);

  always_ff @(posedge clk) begin
    if (rst) begin
      mem_addr  <= '0;
      mem_dq_o  <= '0;
      rsp_valid <= 1'b0;
      rsp_rdata <= '0;
    end else begin
      rsp_valid <= cap_now;
      if (accept) begin
        mem_addr <= req_addr;
        mem_dq_o <= req_wdata;
      end
      if (cap_now) begin
        rsp_rdata <= mem_dq_i;
      end
    end
  end

endmodule

// File: rtl/sram_async_ctrl.sv
module sram_async_ctrl
  import sramc_pkg::*;
#(
  parameter int AW        = 17,
  parameter int DW        = 8,
  parameter int CLK_NS    = 10,
  parameter int T_ACC_NS  = 10,
  parameter int T_RC_NS   = 10,
  parameter int T_PW_NS   = 7,
  parameter int T_PW2_NS  = 10,
  parameter int T_DS_NS   = 5,
  parameter int T_AS_NS   = 8,
  parameter int T_CS_NS   = 7,
  parameter int TURN_CYC  = 1,
  parameter bit OE_LOW_WR = 1'b0
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          req_valid,
  input  logic          req_write,
  input  logic [AW-1:0] req_addr,
  input  logic [DW-1:0] req_wdata,
  output logic          req_ready,
  output logic          rsp_valid,
  output logic [DW-1:0] rsp_rdata,
  output logic          wr_done,
  output logic          mem_ce_n,
  output logic          mem_oe_n,
  output logic          mem_we_n,
  output logic [AW-1:0] mem_addr,
  output logic [DW-1:0] mem_dq_o,
  output logic          mem_dq_oe,
  input  logic [DW-1:0] mem_dq_i
);

  // One extra read cycle gives register sampling margin after the access time.
  localparam int RD_CNT = max_i(ns_to_cyc(T_ACC_NS, CLK_NS) + 1, ns_to_cyc(T_RC_NS, CLK_NS));
  // Address and chip select lead the strobe by the setup cycle.
  localparam int LEAD_CNT = max_i(ns_to_cyc(T_AS_NS, CLK_NS), ns_to_cyc(T_CS_NS, CLK_NS)) - 1;
  localparam int PW_CNT   = OE_LOW_WR ? ns_to_cyc(T_PW2_NS, CLK_NS)
                                      : ns_to_cyc(T_PW_NS, CLK_NS);
  // With output enable low the drivers start one cycle into the strobe.
  localparam int DS_CNT   = ns_to_cyc(T_DS_NS, CLK_NS) + (OE_LOW_WR ? 1 : 0);
  localparam int WP_CNT   = max_i(max_i(PW_CNT, DS_CNT), max_i(LEAD_CNT, 1));
  localparam int TURN_CNT = max_i(TURN_CYC, 1);
  localparam int MAX_CNT  = max_i(max_i(RD_CNT, WP_CNT), TURN_CNT);
  localparam int CW       = $clog2(MAX_CNT + 1);

  logic          t_load;
  logic [CW-1:0] t_val;
  logic          t_zero;
  logic          accept;
  logic          cap_now;
  logic          idle;

  sramc_timer #(.CW(CW)) u_timer (
    .clk      (clk),
    .rst      (rst),
    .load     (t_load),
    .load_val (t_val),
    .zero     (t_zero)
  );

  sramc_seq #(
    .CW        (CW),
    .RD_CNT    (RD_CNT),
    .WP_CNT    (WP_CNT),
    .TURN_CNT  (TURN_CNT),
    .OE_LOW_WR (OE_LOW_WR)
  ) u_seq (
    .clk       (clk),
    .rst       (rst),
    .req_valid (req_valid),
    .req_write (req_write),
    .t_zero    (t_zero),
    .t_load    (t_load),
    .t_val     (t_val),
    .idle      (idle),
    .accept    (accept),
    .cap_now   (cap_now),
    .ce_n      (mem_ce_n),
    .oe_n      (mem_oe_n),
    .we_n      (mem_we_n),
    .drv       (mem_dq_oe),
    .wr_done   (wr_done)
  );

  sramc_dp #(.AW(AW), .DW(DW)) u_dp (
    .clk       (clk),
    .rst       (rst),
    .accept    (accept),
    .req_addr  (req_addr),
    .req_wdata (req_wdata),
    .cap_now   (cap_now),
    .mem_dq_i  (mem_dq_i),
    .mem_addr  (mem_addr),
    .mem_dq_o  (mem_dq_o),
    .rsp_valid (rsp_valid),
    .rsp_rdata (rsp_rdata)
  );

  assign req_ready = idle;

endmodule

// File: rtl/sramc_chk.sv
module sramc_chk #(
  parameter int AW        = 17,
  parameter int DW        = 8,
  parameter bit OE_LOW_WR = 1'b0
) (
  input logic          clk,
  input logic          rst,
  input logic          req_ready,
  input logic          rsp_valid,
  input logic          mem_ce_n,
  input logic          mem_oe_n,
  input logic          mem_we_n,
  input logic [AW-1:0] mem_addr,
  input logic [DW-1:0] mem_dq_o,
  input logic          mem_dq_oe
);

  // R1 / R10: an idle controller leaves the memory deselected with drivers off
  p_standby_r1: assert property (@(posedge clk) disable iff (rst)
    req_ready |-> (mem_ce_n && mem_oe_n && mem_we_n && !mem_dq_oe));

  // R2: the write strobe only appears under chip select
  p_we_in_ce_r2: assert property (@(posedge clk) disable iff (rst)
    !mem_we_n |-> !mem_ce_n);

  // R3: data is driven and unchanged in the cycle after the strobe rises
  p_data_hold_r3: assert property (@(posedge clk) disable iff (rst)
    $rose(mem_we_n) |-> (mem_dq_oe && $stable(mem_dq_o)));

  // R4: output enable stays high throughout the strobe
  p_oe_high_wr_r4: assert property (@(posedge clk) disable iff (rst)
    (!mem_we_n && !OE_LOW_WR) |-> mem_oe_n);

  // R5: the read response is a single-cycle pulse
  p_rsp_pulse_r5: assert property (@(posedge clk) disable iff (rst)
    rsp_valid |=> !rsp_valid);

  // R6: drivers switch on only after output enable was high
  p_turnaround_r6: assert property (@(posedge clk) disable iff (rst)
    (mem_dq_oe && !OE_LOW_WR) |-> ($past(mem_oe_n) && mem_oe_n));

  // R8: address held while chip select stays low
  p_addr_hold_r8: assert property (@(posedge clk) disable iff (rst)
    (!mem_ce_n && $past(!mem_ce_n)) |-> $stable(mem_addr));

endmodule

bind sram_async_ctrl sramc_chk #(.AW(AW), .DW(DW), .OE_LOW_WR(OE_LOW_WR)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .req_ready (req_ready),
  .rsp_valid (rsp_valid),
  .mem_ce_n  (mem_ce_n),
  .mem_oe_n  (mem_oe_n),
  .mem_we_n  (mem_we_n),
  .mem_addr  (mem_addr),
  .mem_dq_o  (mem_dq_o),
  .mem_dq_oe (mem_dq_oe)
);

// File: tb/sim_sram_async_ctrl.sv
module sim_sram_async_ctrl;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        req_valid = 1'b0;
  logic        req_write = 1'b0;
  logic [16:0] req_addr = '0;
  logic [7:0]  req_wdata = '0;
  logic        req_ready, rsp_valid, wr_done;
  logic [7:0]  rsp_rdata;
  logic        mem_ce_n, mem_oe_n, mem_we_n, mem_dq_oe;
  logic [16:0] mem_addr;
  logic [7:0]  mem_dq_o;
  logic [7:0]  mem_dq_i = 8'hEE;

  always #5 clk = ~clk;

  sram_async_ctrl u0 (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_write(req_write),
    .req_addr(req_addr), .req_wdata(req_wdata), .req_ready(req_ready),
    .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata), .wr_done(wr_done),
    .mem_ce_n(mem_ce_n), .mem_oe_n(mem_oe_n), .mem_we_n(mem_we_n),
    .mem_addr(mem_addr), .mem_dq_o(mem_dq_o), .mem_dq_oe(mem_dq_oe),
    .mem_dq_i(mem_dq_i)
  );

  int n_chk = 0;
  int n_fail = 0;
  int n_viol = 0;
  int n_rsp = 0;
  logic [7:0] last_rd = '0;

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  // Behavioural memory, evaluated away from the active edge.
  logic [7:0]  mem_m [int];
  int          w_low = 0;
  int          rd_age = 0;
  logic [7:0]  w_dat = '0;
  logic [16:0] w_adr = '0;

  always @(negedge clk) begin
    if (!rst) begin
      if (rsp_valid) begin
        n_rsp++;
        last_rd = rsp_rdata;
      end
      if (mem_dq_oe && !mem_ce_n && !mem_oe_n && mem_we_n) begin
        n_viol++; $display("model: bus contention (R6)");
      end
      if (!mem_we_n && !mem_oe_n) begin
        n_viol++; $display("model: oe low during strobe (R4)");
      end
      if (!mem_ce_n && !mem_we_n) begin
        if (!mem_dq_oe) begin n_viol++; $display("model: data not driven (R3)"); end
        if (w_low == 0) begin
          w_dat = mem_dq_o; w_adr = mem_addr;
        end else if (mem_dq_o != w_dat || mem_addr != w_adr) begin
          n_viol++; $display("model: data or address moved in strobe (R3)");
        end
        w_low++;
      end else if (w_low > 0) begin
        if (!mem_dq_oe || mem_dq_o != w_dat) begin
          n_viol++; $display("model: data hold missed (R3)");
        end
        mem_m[int'(w_adr)] = w_dat;
        w_low = 0;
      end
      if (!mem_ce_n && !mem_oe_n && mem_we_n) rd_age++;
      else rd_age = 0;
      if (rd_age >= 2)
        mem_dq_i = mem_m.exists(int'(mem_addr)) ? mem_m[int'(mem_addr)] : 8'h00;
      else
        mem_dq_i = 8'hEE;
    end
  end

  int cyc = 0;
  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual %0d expected below 150000 cycles", cyc);
      summary();
    end
  end

  logic [7:0] ref_m [int];

  task automatic do_write(input logic [16:0] a, input logic [7:0] d,
                          output int ce_lo, output int we_lo, output int busy, output bit done);
    while (!req_ready) @(negedge clk);
    req_valid = 1'b1; req_write = 1'b1; req_addr = a; req_wdata = d;
    @(negedge clk);
    req_valid = 1'b0;
    ce_lo = 0; we_lo = 0; busy = 0;
    while (!req_ready) begin
      busy++;
      if (!mem_ce_n) ce_lo++;
      if (!mem_we_n) we_lo++;
      @(negedge clk);
    end
    done = wr_done;
    ref_m[int'(a)] = d;
  endtask

  task automatic do_read(input logic [16:0] a, output logic [7:0] d,
                         output int ce_lo, output int busy, output int pulses);
    int start;
    while (!req_ready) @(negedge clk);
    start = n_rsp;
    req_valid = 1'b1; req_write = 1'b0; req_addr = a;
    @(negedge clk);
    req_valid = 1'b0;
    ce_lo = 0; busy = 0;
    while (!req_ready) begin
      busy++;
      if (!mem_ce_n && !mem_oe_n) ce_lo++;
      @(negedge clk);
    end
    pulses = n_rsp - start;
    d = last_rd;
  endtask

  localparam int NV = 8;
  localparam logic [25:0] VEC [NV] = '{
    {1'b1, 17'h00000, 8'hA5}, {1'b1, 17'h1FFFF, 8'h3C},
    {1'b0, 17'h00000, 8'hA5}, {1'b0, 17'h1FFFF, 8'h3C},
    {1'b1, 17'h0AAAA, 8'hFF}, {1'b1, 17'h15555, 8'h00},
    {1'b0, 17'h0AAAA, 8'hFF}, {1'b0, 17'h15555, 8'h00}
  };

  initial begin
    int ce_lo, we_lo, busy, pulses, bad;
    bit done;
    logic [7:0] d;

    repeat (3) @(negedge clk);
    // R1: reset state
    check(mem_ce_n && mem_oe_n && mem_we_n && !mem_dq_oe && req_ready && !rsp_valid,
          "R1 reset pins", {mem_ce_n, mem_oe_n, mem_we_n, mem_dq_oe, req_ready}, 5'b11101);
    rst = 1'b0;
    @(negedge clk);
    check(req_ready && mem_ce_n, "R1 idle after reset", {req_ready, mem_ce_n}, 2'b11);

    // Table walk
    for (int i = 0; i < NV; i++) begin
      if (VEC[i][25]) begin
        do_write(VEC[i][24:8], VEC[i][7:0], ce_lo, we_lo, busy, done);
        check(ce_lo == 3, "R2 write chip-select cycles", ce_lo, 3);
        check(we_lo == 1, "R2 write strobe cycles", we_lo, 1);
        check(done, "R2 write done pulse", int'(done), 1);
      end else begin
        do_read(VEC[i][24:8], d, ce_lo, busy, pulses);
        check(d == VEC[i][7:0], "R9 table read-back", d, VEC[i][7:0]);
        check(ce_lo == 2, "R5 read select cycles", ce_lo, 2);
        check(busy == 3, "R5 read busy with turnaround", busy, 3);
        check(pulses == 1, "R5 one response pulse", pulses, 1);
      end
    end

    // R10: standby between operations, done pulse gone
    @(negedge clk);
    check(req_ready && mem_ce_n && !mem_dq_oe && !wr_done && !rsp_valid,
          "R10 idle standby", {req_ready, mem_ce_n, mem_dq_oe}, 3'b110);

    // R7: request while busy is ignored
    do_write(17'h00123, 8'h77, ce_lo, we_lo, busy, done);
    @(negedge clk);
    req_valid = 1'b1; req_write = 1'b0; req_addr = 17'h00123;
    @(negedge clk);
    req_write = 1'b1; req_wdata = 8'h11;
    check(!req_ready, "R10 busy during read", int'(req_ready), 0);
    @(negedge clk);
    req_valid = 1'b0;
    while (!req_ready) @(negedge clk);
    check(last_rd == 8'h77, "R7 read during ignored request", last_rd, 8'h77);
    repeat (3) @(negedge clk);
    check(mem_ce_n && !wr_done, "R7 no extra access", int'(mem_ce_n), 1);
    do_read(17'h00123, d, ce_lo, busy, pulses);
    check(d == 8'h77, "R7 location untouched", d, 8'h77);

    // R9: overwrite
    do_write(17'h1FFFF, 8'hC3, ce_lo, we_lo, busy, done);
    do_read(17'h1FFFF, d, ce_lo, busy, pulses);
    check(d == 8'hC3, "R9 overwrite read-back", d, 8'hC3);

    // R9: randomized write then read-back, back-to-back writes
    bad = 0;
    for (int k = 0; k < 40; k++) begin
      logic [16:0] a;
      logic [7:0]  v;
      a = 17'($urandom());
      v = 8'($urandom());
      do_write(a, v, ce_lo, we_lo, busy, done);
      do_read(a, d, ce_lo, busy, pulses);
      if (d != v) bad++;
    end
    check(bad == 0, "R9 random read-back mismatches", bad, 0);
    bad = 0;
    foreach (ref_m[key]) begin
      do_read(17'(key), d, ce_lo, busy, pulses);
      if (d != ref_m[key]) bad++;
    end
    check(bad == 0, "R9 final sweep mismatches", bad, 0);

    // R3 / R4 / R6: memory model rule violations over the whole run
    check(n_viol == 0, "R3 R4 R6 model violations", n_viol, 0);
    check(mem_ce_n && mem_oe_n && mem_we_n && !mem_dq_oe, "R1 final standby",
          {mem_ce_n, mem_oe_n, mem_we_n, mem_dq_oe}, 4'b1110);
    summary();
  end

endmodule